// File: doc/BRIEF.md
# Glitch-Free Selectable Clock Output Divider

This block builds one clock output from a choice of seven internal sources. The sources are the reference clock and the in-phase or inverted output of each of three PLLs. A 3-bit source code picks one of them. The picked clock goes through a 7-bit linear divider. The divider counts both edges of the source, so odd ratios still give a 50% duty cycle. A ratio of zero switches the output off and drops its enable.

Two divide-ratio registers (bank 0 and bank 1) feed the divider, and a bank-select input chooses between them. The divider picks up a new ratio only at the rising source edge that ends the current output period. A bank switch or a ratio change therefore never produces a shortened high or low phase.

The block runs on a fast sampling clock `clk`. The source clocks are level inputs sampled by `clk`, and each source level must hold for at least one `clk` cycle. The output lags the picked source by two `clk` cycles. The output enable is a separate port rather than a pad model.

Top module: `clkdiv_out`

## Requirements
- R1: Source code 000 picks the reference. Codes 010, 100 and 110 pick PLL1, PLL2 and PLL3 in phase, following the rule index = code[2:1]-1.
- R2: Codes 011, 101 and 111 pick the same PLLs inverted (180 degrees). Bit 0 of the code is the inversion bit.
- R3: Code 001 is reserved. One cycle after `clk` samples this code, `oe` and `clkOut` are low, and they stay low while the code is held.
- R4: A running divider with ratio N (1..127) produces one output period per N source periods. Each output rising edge comes two `clk` cycles after the sampled source rising edge that starts the period.
- R5: With an odd or even N, the output high phase and the output low phase each last N source half-periods.
- R6: With N = 1, `clkOut` equals the picked source delayed by two `clk` cycles.
- R7: When the ratio in effect is 0, `oe` is low and `clkOut` is low. If the ratio becomes 0 while the divider is running, the output turns off at the end of the current output period.
- R8: When `bankSel` is 0, the ratio comes from `divBank0`. When `bankSel` is 1, it comes from `divBank1`.
- R9: A change of bank or of ratio takes effect only at the source rising edge that closes the current output period. Every phase after the change is a full phase of either the old ratio or the new one.
- R10: From the off state, the divider starts at the first sampled source rising edge at which the chosen ratio is nonzero. `oe` goes high together with `clkOut`.
- R11: During and directly after reset, `clkOut` and `oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rstN | input | 1 | Active-low synchronous reset |
| refClk | input | 1 | Reference clock level |
| pllClk | input | 3 | PLL output levels, bit k is PLL k+1 |
| srcCode | input | 3 | Source select code |
| divBank0 | input | 7 | Divide ratio, bank 0 |
| divBank1 | input | 7 | Divide ratio, bank 1 |
| bankSel | input | 1 | Bank select, 1 chooses bank 1 |
| clkOut | output | 1 | Divided clock |
| oe | output | 1 | Output enable; low means tri-state |

## Verification
Two events can land on the same `clk` cycle: a ratio reload and a period-closing source rising edge. A ratio change made through the bank select, a direct write, or a zero ratio must wait for that edge and must not cut the phase in progress. The bench changes `bankSel` and the ratio registers at arbitrary cycles inside an output period. It also switches the ratio to zero while the divider runs. A behavioural model predicts `clkOut` and `oe` on every cycle. A run-length monitor checks that every high and low phase has the full length of either the old ratio or the new one.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Strobes from control to datapath; at most one is set in any cycle.
  typedef struct packed {
    logic load;     // start a new output period with newRatio
    logic advance;  // step one source half-period within the period
    logic halt;     // stop and clear the divider
  } divStrobe_t;

endpackage

// File: rtl/clkdiv_src_select.sv
module clkdiv_src_select #(
  parameter int NUM_PLL = 3,
  parameter int CODE_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refClk,
  input  logic [NUM_PLL-1:0] pllClk,
  input  logic [CODE_W-1:0]  srcCode,
  output logic               srcRise,
  output logic               srcFall,
  output logic               reservedSel
);

  localparam int NUM_SRC = 2 * NUM_PLL + 2;
  localparam int RSV_CODE = 1;

  logic [NUM_SRC-1:0] srcVec;
  logic selLvl;
  logic srcQ1, srcQ2;

  assign srcVec[0] = refClk;
  assign srcVec[RSV_CODE] = 1'b0;

  // Each PLL provides an in-phase and an inverted source.
  for (genvar k = 0; k < NUM_PLL; k++) begin : g_pllPhase
    assign srcVec[2*k+2] = pllClk[k];
    assign srcVec[2*k+3] = ~pllClk[k];
  end

  assign selLvl = srcVec[srcCode];
  assign reservedSel = (srcCode == CODE_W'(RSV_CODE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ1 <= 1'b0;
      srcQ2 <= 1'b0;
    end else begin
      srcQ1 <= selLvl;
      srcQ2 <= srcQ1;
    end
  end

  assign srcRise = srcQ1 & ~srcQ2;
  assign srcFall = ~srcQ1 & srcQ2;

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               srcRise,
  input  logic               srcFall,
  input  logic               reservedSel,
  input  logic               atEnd,
  input  logic [RATIO_W-1:0] divBank0,
  input  logic [RATIO_W-1:0] divBank1,
  input  logic               bankSel,
  output divStrobe_t         strobe,
  output logic [RATIO_W-1:0] newRatio,
  output logic               running
);

  logic candNz;
  logic runNext;

  assign newRatio = bankSel ? divBank1 : divBank0;
  assign candNz = (newRatio != '0);

  always_comb begin
    strobe  = '0;
    runNext = running;
    if (reservedSel) begin
      strobe.halt = 1'b1;
      runNext = 1'b0;
    end else if (running) begin
      if (srcRise && atEnd) begin
        if (candNz) begin
          strobe.load = 1'b1;
        end else begin
          strobe.halt = 1'b1;
          runNext = 1'b0;
        end
      end else if (srcRise || srcFall) begin
        strobe.advance = 1'b1;
      end
    end else if (srcRise && candNz) begin
      strobe.load = 1'b1;
      runNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) running <= 1'b0;
    else       running <= runNext;
  end

  AST_RSV_OFF: assert property (@(posedge clk) disable iff (!rstN)
    reservedSel |=> !running); // R3

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe)); // R9

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  divStrobe_t         strobe,
  input  logic [RATIO_W-1:0] newRatio,
  output logic               atEnd,
  output logic               divOut
);

  // The counter runs over source half-periods: 0 .. 2*ratio-1.
  localparam int CNT_W = RATIO_W + 1;

  logic [RATIO_W-1:0] actRatio;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   cntInc;
  logic [CNT_W-1:0]   lastIdx;

  assign lastIdx = {actRatio, 1'b0} - CNT_W'(1);
  assign cntInc  = cnt + CNT_W'(1);
  assign atEnd   = (cnt == lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actRatio <= '0;
      cnt      <= '0;
      divOut   <= 1'b0;
    end else if (strobe.halt) begin
      actRatio <= '0;
      cnt      <= '0;
      divOut   <= 1'b0;
    end else if (strobe.load) begin
      actRatio <= newRatio;
      cnt      <= '0;
      divOut   <= 1'b1;
    end else if (strobe.advance) begin
      cnt      <= cntInc;
      divOut   <= (cntInc < {1'b0, actRatio});
    end
  end

  AST_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |-> (newRatio != '0)); // R7

  AST_LOAD_RISES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> divOut); // R4

  AST_HALT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.halt |=> !divOut); // R7

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (actRatio != '0) |-> (cnt <= lastIdx)); // R5

endmodule

// File: rtl/clkdiv_out.sv
module clkdiv_out
  import clkdiv_pkg::*;
#(
  parameter int NUM_PLL = 3,
  parameter int CODE_W  = 3,
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               refClk,
  input  logic [NUM_PLL-1:0] pllClk,
  input  logic [CODE_W-1:0]  srcCode,
  input  logic [RATIO_W-1:0] divBank0,
  input  logic [RATIO_W-1:0] divBank1,
  input  logic               bankSel,
  output logic               clkOut,
  output logic               oe
);

  logic srcRise, srcFall, reservedSel, atEnd, running, divOut;
  logic [RATIO_W-1:0] newRatio;
  divStrobe_t strobe;

  clkdiv_src_select #(.NUM_PLL(NUM_PLL), .CODE_W(CODE_W)) u_src (
    .clk(clk), .rstN(rstN), .refClk(refClk), .pllClk(pllClk),
    .srcCode(srcCode), .srcRise(srcRise), .srcFall(srcFall),
    .reservedSel(reservedSel)
  );

  clkdiv_ctrl #(.RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcRise(srcRise), .srcFall(srcFall),
    .reservedSel(reservedSel), .atEnd(atEnd), .divBank0(divBank0),
    .divBank1(divBank1), .bankSel(bankSel), .strobe(strobe),
    .newRatio(newRatio), .running(running)
  );

  clkdiv_datapath #(.RATIO_W(RATIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .newRatio(newRatio),
    .atEnd(atEnd), .divOut(divOut)
  );

  assign clkOut = divOut;
  assign oe     = running;

  AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !oe |-> !clkOut); // R7

endmodule

// File: tb/clkdiv_out_tb.sv
module clkdiv_out_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refClk = 1'b0;
  logic [2:0] pllClk = '0;
  logic [2:0] srcCode = '0;
  logic [6:0] divBank0 = '0;
  logic [6:0] divBank1 = '0;
  logic bankSel = 1'b0;
  logic clkOut, oe;

  int errors = 0;
  int checks = 0;
  string curReq = "R11";

  clkdiv_out u_dut (
    .clk(clk), .rstN(rstN), .refClk(refClk), .pllClk(pllClk),
    .srcCode(srcCode), .divBank0(divBank0), .divBank1(divBank1),
    .bankSel(bankSel), .clkOut(clkOut), .oe(oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Source generators: half-periods in clk cycles
  int halfRef = 3, halfP1 = 2, halfP2 = 5, halfP3 = 4;
  int cRef = 0, cP1 = 0, cP2 = 0, cP3 = 0;
  always @(posedge clk) begin
    #1;
    cRef++; if (cRef >= halfRef) begin cRef = 0; refClk = ~refClk; end
    cP1++;  if (cP1 >= halfP1)   begin cP1 = 0; pllClk[0] = ~pllClk[0]; end
    cP2++;  if (cP2 >= halfP2)   begin cP2 = 0; pllClk[1] = ~pllClk[1]; end
    cP3++;  if (cP3 >= halfP3)   begin cP3 = 0; pllClk[2] = ~pllClk[2]; end
  end

  // Behavioural reference model
  int mQ1 = 0, mQ2 = 0, mRun = 0, mOut = 0, mN = 0, mHalf = 0;
  always @(posedge clk) begin
    int sel, cand, rise, fall;
    case (srcCode)
      3'd0: sel = refClk;
      3'd1: sel = 0;
      default: begin
        sel = pllClk[srcCode[2:1] - 2'd1];
        if (srcCode[0]) sel = 1 - sel;
      end
    endcase
    cand = bankSel ? int'(divBank1) : int'(divBank0);
    rise = (mQ1 == 1 && mQ2 == 0);
    fall = (mQ1 == 0 && mQ2 == 1);
    if (!rstN) begin
      mQ1 = 0; mQ2 = 0; mRun = 0; mOut = 0; mN = 0; mHalf = 0;
    end else begin
      if (srcCode == 3'd1) begin
        mRun = 0; mOut = 0; mHalf = 0; mN = 0;
      end else if (mRun == 1) begin
        if (rise && mHalf == 2*mN - 1) begin
          if (cand != 0) begin mN = cand; mHalf = 0; mOut = 1; end
          else begin mRun = 0; mOut = 0; mHalf = 0; mN = 0; end
        end else if (rise || fall) begin
          mHalf++;
          mOut = (mHalf < mN) ? 1 : 0;
        end
      end else if (rise && cand != 0) begin
        mRun = 1; mN = cand; mHalf = 0; mOut = 1;
      end
      mQ2 = mQ1;
      mQ1 = sel;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  bit cmpOn = 0;
  always @(negedge clk) begin
    if (cmpOn) begin
      check(clkOut === 1'(mOut), {curReq, " clkOut"}, int'(clkOut), mOut);
      check(oe === 1'(mRun), {curReq, " oe"}, int'(oe), mRun);
    end
  end

  // Phase-length monitor
  int monA = 0, monB = 0, runLen = 0;
  logic lastLvl = 1'b0;
  always @(negedge clk) begin
    if (oe !== 1'b1) begin
      runLen = 0;
    end else if (clkOut === lastLvl) begin
      runLen++;
    end else begin
      if (runLen > 0 && monA != 0)
        check(runLen == monA || runLen == monB, {curReq, " phase length"}, runLen, monA);
      runLen = 1;
    end
    lastLvl = clkOut;
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic runTests();
    // R11 reset state
    cyc(3);
    @(negedge clk);
    check(clkOut === 1'b0 && oe === 1'b0, "R11 reset", int'(clkOut), 0);
    cyc(1);
    rstN = 1'b1;
    cmpOn = 1;
    cyc(2);
    @(negedge clk);
    check(oe === 1'b0, "R11 after reset", int'(oe), 0);

    // R4/R5: odd ratio 3 on the reference, half-period 3 clk -> phases of 9
    curReq = "R5";
    divBank0 = 7'd3; divBank1 = 7'd4; bankSel = 1'b0; srcCode = 3'd0;
    monA = 9; monB = 9;
    cyc(150);
    @(negedge clk);
    check(oe === 1'b1, "R4 running", int'(oe), 1);

    // R8/R9: bank switch at an arbitrary cycle
    curReq = "R9";
    monA = 9; monB = 12;
    cyc(4);
    bankSel = 1'b1;
    cyc(200);
    curReq = "R8";
    cyc(40);

    // R6: direct write of ratio 1 into the active bank
    curReq = "R6";
    monA = 3; monB = 12;
    cyc(5);
    divBank1 = 7'd1;
    cyc(120);

    // R1/R2: every source code, ratio 2
    monA = 0;
    divBank0 = 7'd2; bankSel = 1'b0;
    for (int c = 2; c < 8; c++) begin
      curReq = (c % 2 == 0) ? "R1" : "R2";
      srcCode = 3'(c);
      cyc(80);
    end
    curReq = "R1";
    srcCode = 3'd0;
    cyc(60);

    // R3: reserved code
    curReq = "R3";
    srcCode = 3'd1;
    cyc(20);
    @(negedge clk);
    check(oe === 1'b0 && clkOut === 1'b0, "R3 reserved off", int'(oe), 0);

    // R7: zero ratio keeps the output off
    curReq = "R7";
    divBank0 = 7'd0;
    srcCode = 3'd0;
    cyc(50);
    @(negedge clk);
    check(oe === 1'b0, "R7 zero ratio off", int'(oe), 0);

    // R10: nonzero ratio starts the divider
    curReq = "R10";
    divBank0 = 7'd5;
    cyc(40);
    @(negedge clk);
    check(oe === 1'b1, "R10 started", int'(oe), 1);

    // R7: ratio goes to zero while running
    curReq = "R7";
    monA = 15; monB = 15;
    cyc(7);
    divBank0 = 7'd0;
    cyc(60);
    @(negedge clk);
    check(oe === 1'b0 && clkOut === 1'b0, "R7 off after period", int'(oe), 0);
    monA = 0;
  endtask

  initial begin
    bit timedOut = 0;
    fork
      runTests();
      begin
        for (int i = 0; i < WATCHDOG_CYC; i++) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule